// File: doc/BRIEF.md
# Configuration Image Sync Hunter and Bit Serializer

This block sits between a byte source holding a configuration image and a serial configuration port. The image arrives with a header of unknown length in front of it. The block consumes header bytes silently until it sees the two-byte synchronization marker: 0xFF, then a byte whose upper nibble is 0x2 and whose lower nibble matches the parameter `LEN_NIBBLE`. From that marker on it shifts every byte out, most significant bit first, one bit per bit-enable tick. The marker itself goes first.

The byte input is valid/ready. A byte transfers on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. While hunting, `in_ready_o` is held high, so one header byte is taken every cycle. After lock, `in_ready_o` is high only while the serializer is empty. It drops in the cycle after a byte is taken and rises again in the cycle whose edge shifted that byte's last bit. The source may hold `in_valid_i` low for any time and must keep `in_data_i` stable while it waits for ready.

`sync_found_o` reports the lock. It stays high until reset or the synchronous `restart_i`, and both of those return the block to hunting.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, and in the cycle after `restart_i` is high at a clock edge, `sync_found_o`=0, `ser_strobe_o`=0, `ser_data_o`=1 and `in_ready_o`=1.
- R2: While `sync_found_o` is 0, `ser_strobe_o` stays 0 and `ser_data_o` stays 1. No header byte ever appears on the serial output.
- R3: The marker is 0xFF followed directly by the byte {4'h2, LEN_NIBBLE}, with LEN_NIBBLE defaulting to 0 (0x20). With the default, the pair 0xFF,0x21 is not a marker.
- R4: The first serial bits after lock are the marker bytes, MSB first: 1,1,1,1,1,1,1,1,0,0,1,0,0,0,0,0 for the default.
- R5: Every byte after the marker is serialized unchanged and in arrival order, MSB first.
- R6: A byte after 0xFF that is not the second marker byte resumes the hunt. If that byte is 0xFF, it becomes the new first-byte candidate, so 0xFF,0xFF,0x20 locks.
- R7: Only the first marker after reset or restart is recognized. Later 0xFF,0x2X pairs are payload data.
- R8: Exactly one bit is emitted per `bit_tick_i` that is high at a clock edge while bits are pending. `ser_strobe_o` is high for the cycle after that edge and is never high without such a tick.
- R9: After lock, `in_ready_o` is 0 while a taken byte still has bits left to shift.
- R10: `sync_found_o` rises in the cycle after the second marker byte is taken and stays high until `restart_i` or reset.
- R11: `restart_i` aborts any pending bits and returns the block to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous return to hunting |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block can take a byte |
| bit_tick_i | input | 1 | Bit-rate enable, one bit per high cycle |
| ser_data_o | output | 1 | Serial data, valid while strobe is high, 1 otherwise |
| ser_strobe_o | output | 1 | One-cycle pulse per emitted bit |
| sync_found_o | output | 1 | Marker recognized |

## Verification
Random headers that never contain the marker pair, combined with random payloads, show whether header bytes are dropped and whether the payload is passed on bit-exactly. Directed streams separate the cases around the marker:
- 0xFF,0x21 early in the header tests that the nibble choice is honoured.
- 0xFF,0xFF,0x20 tests that a false start keeps its candidate.
- 0xFF,0x2F tests that the hunt resumes after a near miss.
- A payload that carries 0xFF,0x20 tests that later marker pairs are treated as data.
- A stream with no marker tests that nothing is emitted.

Sparse random ticks and a constant tick tell the pacing rules apart from the back-pressure rules. A restart in the middle of a byte tests that pending bits are aborted.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MARK_HI = 8'hFF;
  localparam logic [3:0] MARK_LO_TOP = 4'h2;

  typedef enum logic [1:0] {
    HUNT_SCAN,
    HUNT_CAND,
    HUNT_LOCK
  } hunt_state_e;
endpackage

// File: rtl/cfgld_hunter.sv
module cfgld_hunter
  import cfgld_pkg::*;
#(
  parameter int LEN_NIBBLE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              fire,
  input  logic [BYTE_W-1:0] data,
  output logic              locked,
  output logic              load_pair,
  output logic              load_one
);
  localparam logic [BYTE_W-1:0] MARK_LO = {MARK_LO_TOP, 4'(LEN_NIBBLE)};

  hunt_state_e state_q, state_d;
  logic is_hi, is_lo;

  assign is_hi = (data == MARK_HI);
  assign is_lo = (data == MARK_LO);

  always_comb begin
    state_d   = state_q;
    load_pair = 1'b0;
    load_one  = 1'b0;
    case (state_q)
      HUNT_SCAN: if (fire && is_hi) state_d = HUNT_CAND;
      HUNT_CAND: begin
        if (fire) begin
          if (is_lo) begin
            state_d   = HUNT_LOCK;
            load_pair = 1'b1;
          end else if (!is_hi) begin
            state_d = HUNT_SCAN;
          end
        end
      end
      HUNT_LOCK: load_one = fire;
      default:   state_d = HUNT_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= HUNT_SCAN;
    else if (restart) state_q <= HUNT_SCAN;
    else              state_q <= state_d;
  end

  assign locked = (state_q == HUNT_LOCK);
endmodule

// File: rtl/cfgld_serializer.sv
module cfgld_serializer
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              load_pair,
  input  logic              load_one,
  input  logic [BYTE_W-1:0] data,
  input  logic              tick,
  output logic              busy,
  output logic              sdata,
  output logic              strobe
);
  localparam int SH_W  = 2 * BYTE_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      sdata  <= 1'b1;
      strobe <= 1'b0;
    end else if (restart) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      sdata  <= 1'b1;
      strobe <= 1'b0;
    end else begin
      sdata  <= 1'b1;
      strobe <= 1'b0;
      if (load_pair) begin
        sh_q  <= {MARK_HI, data};
        cnt_q <= CNT_W'(SH_W);
      end else if (load_one) begin
        sh_q  <= {data, {BYTE_W{1'b0}}};
        cnt_q <= CNT_W'(BYTE_W);
      end else if (busy && tick) begin
        sdata  <= sh_q[SH_W-1];
        strobe <= 1'b1;
        sh_q   <= {sh_q[SH_W-2:0], 1'b0};
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgld_pkg::*;
#(
  parameter int LEN_NIBBLE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              bit_tick_i,
  output logic              ser_data_o,
  output logic              ser_strobe_o,
  output logic              sync_found_o
);
  logic locked, load_pair, load_one, busy, fire;

  assign in_ready_o = locked ? !busy : 1'b1;
  assign fire       = in_valid_i && in_ready_o && !restart_i;

  cfgld_hunter #(.LEN_NIBBLE(LEN_NIBBLE)) hunt_i (
    .clk(clk), .rst_n(rst_n), .restart(restart_i), .fire(fire),
    .data(in_data_i), .locked(locked), .load_pair(load_pair), .load_one(load_one)
  );

  cfgld_serializer ser_i (
    .clk(clk), .rst_n(rst_n), .restart(restart_i), .load_pair(load_pair),
    .load_one(load_one), .data(in_data_i), .tick(bit_tick_i), .busy(busy),
    .sdata(ser_data_o), .strobe(ser_strobe_o)
  );

  assign sync_found_o = locked;
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic restart_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic bit_tick_i,
  input logic ser_data_o,
  input logic ser_strobe_o,
  input logic sync_found_o
);
  // R2
  scan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_found_o |-> (!ser_strobe_o && ser_data_o));

  // R8
  strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe_o |-> $past(bit_tick_i));

  // R10
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_found_o && !restart_i) |=> sync_found_o);

  // R10
  sync_rise_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_found_o) |-> $past(in_valid_i && in_ready_o));

  // R11
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!sync_found_o && !ser_strobe_o && in_ready_o));
endmodule

bind cfg_stream_loader cfg_stream_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .bit_tick_i(bit_tick_i), .ser_data_o(ser_data_o),
  .ser_strobe_o(ser_strobe_o), .sync_found_o(sync_found_o)
);

// File: tb/cfg_stream_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_stream_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic bit_tick = 1'b0;
  logic ser_data, ser_strobe, sync_found;

  int n_chk = 0;
  int n_bad = 0;
  int obs_idx = 0;
  int tick_mode = 0;
  bit exp_q[$];
  logic [7:0] stim[$];
  logic tick_seen = 1'b0;

  always #10 clk = ~clk;

  cfg_stream_loader dut_i (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready), .bit_tick_i(bit_tick),
    .ser_data_o(ser_data), .ser_strobe_o(ser_strobe), .sync_found_o(sync_found)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int find_mark();
    for (int i = 0; i + 1 < stim.size(); i++)
      if (stim[i] == 8'hFF && stim[i+1] == 8'h20) return i;
    return -1;
  endfunction

  function automatic void build_exp();
    int m;
    exp_q.delete();
    m = find_mark();
    if (m >= 0)
      for (int i = m; i < stim.size(); i++)
        for (int b = 7; b >= 0; b--) exp_q.push_back(stim[i][b]);
  endfunction

  always @(posedge clk) tick_seen <= bit_tick;

  initial begin
    forever begin
      @(posedge clk);
      #3;
      bit_tick = (tick_mode != 0) ? 1'b1 : (($urandom % 3) == 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_strobe) begin
        chk(tick_seen, "R8 strobe without tick", 0, 1);
        if (obs_idx < exp_q.size())
          chk(ser_data == exp_q[obs_idx], "R4/R5 serial bit", ser_data, exp_q[obs_idx]);
        else
          chk(1'b0, "R2/R7 unexpected bit", obs_idx, exp_q.size());
        obs_idx++;
      end
      if (!sync_found)
        chk(!ser_strobe && ser_data, "R2 idle outputs", {ser_strobe, ser_data}, 2'b01);
      if (sync_found && (obs_idx % 8) != 0)
        chk(!in_ready, "R9 ready while shifting", in_ready, 0);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    exp_q.delete();
    obs_idx = 0;
    chk(!sync_found && !ser_strobe && ser_data && in_ready, "R11 restart state",
        {sync_found, ser_strobe, ser_data, in_ready}, 4'b0011);
  endtask

  task automatic run_stream(input string tag);
    build_exp();
    obs_idx = 0;
    foreach (stim[i]) send_byte(stim[i]);
    in_valid = 1'b0;
    while (obs_idx < exp_q.size()) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(obs_idx == exp_q.size(), {tag, " bit count"}, obs_idx, exp_q.size());
    chk(sync_found == (exp_q.size() != 0), {tag, " R10 sync flag"}, sync_found, exp_q.size() != 0);
    do_restart();
  endtask

  task automatic add_rand_header(input int n);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      if (stim.size() > 0 && stim[stim.size()-1] == 8'hFF && b == 8'h20) b = 8'h21;
      stim.push_back(b);
    end
    if (stim.size() > 0 && stim[stim.size()-1] == 8'hFF) stim.push_back(8'h00);
  endtask

  task automatic add_rand_payload(input int n);
    for (int i = 0; i < n; i++) stim.push_back(8'($urandom));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!sync_found && !ser_strobe && ser_data && in_ready, "R1 reset state",
        {sync_found, ser_strobe, ser_data, in_ready}, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sync_found && in_ready, "R1 after reset release", {sync_found, in_ready}, 2'b01);

    // R2: no marker, nothing emitted
    stim = '{8'h00, 8'h09, 8'hFF, 8'h0F, 8'hF0, 8'h61, 8'hFF};
    run_stream("R2 no marker");

    // R3: 0xFF,0x21 is not a marker in the default mode; R4 marker first
    stim = '{8'h01, 8'hFF, 8'h21, 8'h33, 8'hFF, 8'h20, 8'hA3, 8'h1F};
    run_stream("R3 nibble select");

    // R6: candidate kept across repeated 0xFF
    stim = '{8'h44, 8'hFF, 8'hFF, 8'h20, 8'h5F, 8'hF7};
    run_stream("R6 double FF");

    // R6: near miss resumes the hunt
    stim = '{8'hFF, 8'h2F, 8'h20, 8'hFF, 8'h20, 8'hEF};
    run_stream("R6 near miss");

    // R7: later marker pair in payload is data
    tick_mode = 1;
    stim = '{8'h12, 8'hFF, 8'h20, 8'hFF, 8'h20, 8'hFF, 8'h20, 8'h7E};
    run_stream("R7 repeat marker");

    // R4: marker right at the start, constant tick
    stim = '{8'hFF, 8'h20, 8'hDE};
    run_stream("R4 leading marker");
    tick_mode = 0;

    // R11: restart in the middle of a byte
    stim = '{8'h05, 8'hFF, 8'h20, 8'hB5, 8'hFB};
    build_exp();
    obs_idx = 0;
    foreach (stim[i]) send_byte(stim[i]);
    in_valid = 1'b0;
    while (obs_idx < exp_q.size() - 5) @(negedge clk);
    do_restart();
    repeat (40) @(negedge clk);
    chk(obs_idx == 0 && !sync_found, "R11 pending bits aborted", obs_idx, 0);

    // R5: random headers and payloads
    for (int s = 0; s < 10; s++) begin
      tick_mode = (s % 3 == 2) ? 1 : 0;
      stim.delete();
      add_rand_header($urandom % 20);
      stim.push_back(8'hFF);
      stim.push_back(8'h20);
      add_rand_payload(1 + ($urandom % 12));
      run_stream("R5 random stream");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", obs_idx, exp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule